// File: doc/BRIEF.md
# Byte Data Memory with Register-Mapped Pointers

This block is the byte-wide data store of a small 8-bit controller. It holds 112 bytes of general RAM at addresses 0x00 to 0x6F. It also holds a window of sixteen register bytes at 0xF0 to 0xFF. Three of the window bytes are the live address pointers that the rest of the core uses. The primary pointer lives at 0xFE, the alternate pointer at 0xFC and the stack pointer at 0xFD. Any ordinary write to one of those addresses therefore redirects the next indirect, push or pop access.

A single operation is presented on each clock cycle. The operations are:
- direct reads and writes;
- indirect reads and writes through the primary or alternate pointer, with an optional post-step of that pointer;
- stack push and pop through the stack pointer;
- single-bit set, clear and test on any mapped byte;
- a decrement-and-test on window bytes, which raises a skip flag when the result is zero.

Read results, the tested bit and the skip flag are registered. They appear one cycle after the operation is sampled.

Top module: `ptr_data_mem`

## Requirements
- R1: After synchronous reset, `rvalid` and `skip` are 0 and the stack pointer byte at 0xFD reads 0x6F; no other byte has a defined reset value.
- R2: Opcodes on `op`: 0 idle, 1 direct read, 2 direct write, 3 indirect read, 4 indirect write, 5 push, 6 pop, 7 bit set, 8 bit clear, 9 bit test, 10 decrement-and-test. A read-type operation (1, 3, 6, 9) raises `rvalid` for exactly the next cycle, with the byte it read on `rdata`. Direct reads and writes reach 0x00–0x6F and 0xF0–0xFF.
- R3: Addresses 0x70–0xEF are unmapped. Reads of them return 0x00, and writes or bit updates to them change nothing.
- R4: The primary pointer is the byte at 0xFE and the alternate pointer is the byte at 0xFC. A direct write to either address sets the address used by the next indirect access.
- R5: Indirect operations use the primary pointer when `ptr_sel`=0 and the alternate pointer when `ptr_sel`=1. After the access, `step`=1 adds one to the pointer and `step`=2 subtracts one, modulo 256. `step`=0 or 3 leaves the pointer unchanged.
- R6: A push writes `wdata` at the address held in the stack pointer, then decrements the stack pointer.
- R7: A pop increments the stack pointer, then reads the byte at the new address.
- R8: Bit set and bit clear change only bit `bit_sel` (0 = LSB) of the addressed byte. This works on any mapped byte, including the pointer bytes.
- R9: Bit test returns the addressed byte on `rdata`, and bit `bit_sel` of that byte on `bit_out`, without changing the byte.
- R10: Decrement-and-test on a window address writes back the byte minus one, modulo 256. It raises `skip` in the next cycle only when the result is 0. On any other address it changes nothing and `skip` stays 0.
- R11: When an operation writes to the address of the same pointer it would step, the written value is kept and the step is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| op | input | 4 | Operation code (see R2) |
| addr | input | 8 | Direct address for direct, bit and decrement operations |
| wdata | input | 8 | Write data for direct write, indirect write and push |
| bit_sel | input | 3 | Bit index for bit operations |
| ptr_sel | input | 1 | 0 selects the pointer at 0xFE, 1 the pointer at 0xFC |
| step | input | 2 | Post-step for indirect access: 1 increment, 2 decrement |
| rdata | output | 8 | Byte read by the last read-type operation |
| rvalid | output | 1 | High for one cycle after a read-type operation |
| bit_out | output | 1 | Bit returned by the last bit test |
| skip | output | 1 | High for one cycle after a decrement that reached zero |

## Verification
The bench wraps the primary pointer from 0xFF to 0x00 and back. A design that steps with the wrong width would then leave the pointer outside the window or at 0x100. It pushes and pops in pairs and reads the stack pointer between them, which catches pre- versus post-update mistakes as an off-by-one address. It aims a pointer at its own address while also stepping it. A design with the wrong priority would show the stepped value instead of the written one. It also drives unmapped addresses, decrements a byte through zero, and decrements a byte outside the window. These catch aliasing into RAM, a missing or stray skip, and writes that should have been dropped.

// File: rtl/ptr_mem_pkg.sv
// Shared operation and step encodings for the pointer data memory.
package ptr_mem_pkg;

    typedef enum logic [3:0] {
        OP_NOP     = 4'd0,
        OP_RD      = 4'd1,
        OP_WR      = 4'd2,
        OP_IRD     = 4'd3,
        OP_IWR     = 4'd4,
        OP_PUSH    = 4'd5,
        OP_POP     = 4'd6,
        OP_BSET    = 4'd7,
        OP_BCLR    = 4'd8,
        OP_BTST    = 4'd9,
        OP_DECSKIP = 4'd10
    } mem_op_e;

    typedef enum logic [1:0] {
        STEP_NONE = 2'd0,
        STEP_INC  = 2'd1,
        STEP_DEC  = 2'd2,
        STEP_RSV  = 2'd3
    } step_e;

endpackage

// File: rtl/ptr_mem_decode.sv
// Address decoder: classifies a byte address as general RAM, register window
// or unmapped, and produces the local index into the matching store.
// Assumes the RAM starts at address 0 and the window lies above it.
module ptr_mem_decode #(
    parameter int ADDR_W    = 8,
    parameter int RAM_WORDS = 112,
    parameter int WIN_BASE  = 240,
    parameter int WIN_WORDS = 16,
    localparam int RAM_IW   = $clog2(RAM_WORDS),
    localparam int WIN_IW   = $clog2(WIN_WORDS)
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              in_ram,
    output logic              in_win,
    output logic [RAM_IW-1:0] ram_idx,
    output logic [WIN_IW-1:0] win_idx
);
    localparam logic [ADDR_W:0] RAM_END = (ADDR_W+1)'(RAM_WORDS);
    localparam logic [ADDR_W:0] WIN_LO  = (ADDR_W+1)'(WIN_BASE);
    localparam logic [ADDR_W:0] WIN_END = (ADDR_W+1)'(WIN_BASE + WIN_WORDS);

    logic [ADDR_W:0] a_ext;

    // Range compare on a one-bit-wider copy so the window top needs no wrap.
    always_comb begin
        a_ext   = {1'b0, addr};
        in_ram  = a_ext < RAM_END;
        in_win  = (a_ext >= WIN_LO) && (a_ext < WIN_END);
        ram_idx = RAM_IW'(addr);
        win_idx = WIN_IW'(a_ext - WIN_LO);
    end

endmodule

// File: rtl/ptr_mem_ram.sv
// General-purpose byte RAM: one write port and one combinational read port
// sharing an index. Contents have no reset value.
module ptr_mem_ram #(
    parameter int DATA_W    = 8,
    parameter int RAM_WORDS = 112,
    localparam int RAM_IW   = $clog2(RAM_WORDS)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [RAM_IW-1:0] idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem [RAM_WORDS];

    // Store one byte when enabled.
    always_ff @(posedge clk) begin
        if (we) mem[idx] <= wdata;
    end

    assign rdata = mem[idx];

endmodule

// File: rtl/ptr_mem_regwin.sv
// Register window: sixteen byte registers, three of which act as pointers.
// A data write and a pointer step may arrive together. The data write to a
// register always beats a step of that same register. Only the stack pointer
// register has a reset value.
module ptr_mem_regwin #(
    parameter int DATA_W    = 8,
    parameter int WIN_WORDS = 16,
    parameter int P_IDX     = 14,
    parameter int A_IDX     = 12,
    parameter int SP_IDX    = 13,
    parameter int SP_RESET  = 'h6F,
    localparam int WIN_IW   = $clog2(WIN_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [WIN_IW-1:0] widx,
    input  logic [DATA_W-1:0] wdata,
    input  logic              step_en,
    input  logic [WIN_IW-1:0] step_idx,
    input  logic              step_up,
    input  logic [WIN_IW-1:0] ridx,
    output logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] ptr_p,
    output logic [DATA_W-1:0] ptr_a,
    output logic [DATA_W-1:0] ptr_sp
);
    logic [DATA_W-1:0] view [WIN_WORDS];
    logic [DATA_W-1:0] step_cur;

    for (genvar i = 0; i < WIN_WORDS; i++) begin : g_reg
        logic [DATA_W-1:0] q;
        logic              hit_w;
        logic              hit_s;
        assign hit_w = we && (widx == WIN_IW'(i));
        assign hit_s = step_en && (step_idx == WIN_IW'(i));
        if (i == SP_IDX) begin : g_rst
            // Stack pointer: reset to its start value, then write or step.
            always_ff @(posedge clk) begin
                if (!rst_n)     q <= DATA_W'(SP_RESET);
                else if (hit_w) q <= wdata;
                else if (hit_s) q <= step_up ? q + DATA_W'(1) : q - DATA_W'(1);
            end
        end else begin : g_plain
            // Ordinary window byte: write beats step, no reset value.
            always_ff @(posedge clk) begin
                if (hit_w)      q <= wdata;
                else if (hit_s) q <= step_up ? q + DATA_W'(1) : q - DATA_W'(1);
            end
        end
        assign view[i] = q;
    end

    assign rdata    = view[ridx];
    assign ptr_p    = view[P_IDX];
    assign ptr_a    = view[A_IDX];
    assign ptr_sp   = view[SP_IDX];
    assign step_cur = view[step_idx];

    AST_SP_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> ptr_sp == DATA_W'(SP_RESET)); // R1

    AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && !(we && widx == step_idx)) |=>
        view[$past(step_idx)] == ($past(step_up) ? $past(step_cur) + DATA_W'(1)
                                                 : $past(step_cur) - DATA_W'(1))); // R5

    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (we && step_en && widx == step_idx) |=> view[$past(widx)] == $past(wdata)); // R11

endmodule

// File: rtl/ptr_data_mem.sv
// Data memory top: resolves the effective address of each operation
// (direct, through a pointer or through the stack pointer), performs the
// read-modify-write for bit and decrement operations in one cycle, requests
// pointer steps, and registers the read, bit-test and skip results.
// Assumes one operation per cycle and pointers as wide as an address.
module ptr_data_mem
    import ptr_mem_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int ADDR_W    = 8,
    parameter int RAM_WORDS = 112,
    parameter int WIN_BASE  = 240,
    parameter int WIN_WORDS = 16,
    parameter int P_IDX     = 14,
    parameter int A_IDX     = 12,
    parameter int SP_IDX    = 13,
    parameter int SP_RESET  = 'h6F,
    localparam int BIT_W    = $clog2(DATA_W),
    localparam int RAM_IW   = $clog2(RAM_WORDS),
    localparam int WIN_IW   = $clog2(WIN_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        op,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [BIT_W-1:0]  bit_sel,
    input  logic              ptr_sel,
    input  logic [1:0]        step,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid,
    output logic              bit_out,
    output logic              skip
);
    localparam logic [ADDR_W-1:0] SP_ADDR = ADDR_W'(WIN_BASE + SP_IDX);

    mem_op_e           op_q;
    logic [ADDR_W-1:0] eff;
    logic              in_ram, in_win;
    logic [RAM_IW-1:0] ram_idx;
    logic [WIN_IW-1:0] win_idx;
    logic [DATA_W-1:0] ram_rd, win_rd, rd_byte, wr_val, mask;
    logic [DATA_W-1:0] ptr_p, ptr_a, ptr_sp;
    logic              wr_req, is_read;
    logic              step_en, step_up;
    logic [WIN_IW-1:0] step_idx;

    assign op_q = mem_op_e'(op);

    // Pick the effective address and the pointer step request for this op.
    always_comb begin
        eff      = addr;
        step_en  = 1'b0;
        step_up  = 1'b0;
        step_idx = '0;
        case (op_q)
            OP_IRD, OP_IWR: begin
                eff      = ptr_sel ? ADDR_W'(ptr_a) : ADDR_W'(ptr_p);
                step_en  = (step == STEP_INC) || (step == STEP_DEC);
                step_up  = (step == STEP_INC);
                step_idx = ptr_sel ? WIN_IW'(A_IDX) : WIN_IW'(P_IDX);
            end
            OP_PUSH: begin
                eff      = ADDR_W'(ptr_sp);
                step_en  = 1'b1;
                step_idx = WIN_IW'(SP_IDX);
            end
            OP_POP: begin
                eff      = ADDR_W'(ptr_sp + DATA_W'(1));
                step_en  = 1'b1;
                step_up  = 1'b1;
                step_idx = WIN_IW'(SP_IDX);
            end
            default: eff = addr;
        endcase
    end

    ptr_mem_decode #(
        .ADDR_W(ADDR_W), .RAM_WORDS(RAM_WORDS),
        .WIN_BASE(WIN_BASE), .WIN_WORDS(WIN_WORDS)
    ) u_dec (
        .addr(eff), .in_ram(in_ram), .in_win(in_win),
        .ram_idx(ram_idx), .win_idx(win_idx)
    );

    // Merge the two stores; unmapped addresses read as zero.
    always_comb begin
        rd_byte = in_ram ? ram_rd : (in_win ? win_rd : '0);
        mask    = DATA_W'(1) << bit_sel;
    end

    // Compute the value to store and whether this op stores at all.
    always_comb begin
        case (op_q)
            OP_BSET:    wr_val = rd_byte | mask;
            OP_BCLR:    wr_val = rd_byte & ~mask;
            OP_DECSKIP: wr_val = rd_byte - DATA_W'(1);
            default:    wr_val = wdata;
        endcase
        wr_req  = (op_q == OP_WR) || (op_q == OP_IWR) || (op_q == OP_PUSH) ||
                  (op_q == OP_BSET) || (op_q == OP_BCLR) ||
                  ((op_q == OP_DECSKIP) && in_win);
        is_read = (op_q == OP_RD) || (op_q == OP_IRD) ||
                  (op_q == OP_POP) || (op_q == OP_BTST);
    end

    ptr_mem_ram #(.DATA_W(DATA_W), .RAM_WORDS(RAM_WORDS)) u_ram (
        .clk(clk), .we(wr_req && in_ram), .idx(ram_idx),
        .wdata(wr_val), .rdata(ram_rd)
    );

    ptr_mem_regwin #(
        .DATA_W(DATA_W), .WIN_WORDS(WIN_WORDS), .P_IDX(P_IDX),
        .A_IDX(A_IDX), .SP_IDX(SP_IDX), .SP_RESET(SP_RESET)
    ) u_win (
        .clk(clk), .rst_n(rst_n),
        .we(wr_req && in_win), .widx(win_idx), .wdata(wr_val),
        .step_en(step_en), .step_idx(step_idx), .step_up(step_up),
        .ridx(win_idx), .rdata(win_rd),
        .ptr_p(ptr_p), .ptr_a(ptr_a), .ptr_sp(ptr_sp)
    );

    // Register read data, tested bit and skip flag for the following cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata   <= '0;
            rvalid  <= 1'b0;
            bit_out <= 1'b0;
            skip    <= 1'b0;
        end else begin
            rvalid <= is_read;
            if (is_read) rdata <= rd_byte;
            if (op_q == OP_BTST) bit_out <= rd_byte[bit_sel];
            skip <= (op_q == OP_DECSKIP) && in_win && (wr_val == '0);
        end
    end

    AST_SKIP_AFTER_DEC: assert property (@(posedge clk) disable iff (!rst_n)
        skip |-> $past(op_q) == OP_DECSKIP); // R10

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (is_read && !in_ram && !in_win) |=> rdata == '0); // R3

    AST_PUSH_DEC: assert property (@(posedge clk) disable iff (!rst_n)
        (op_q == OP_PUSH && ADDR_W'(ptr_sp) != SP_ADDR) |=>
        ptr_sp == $past(ptr_sp) - DATA_W'(1)); // R6

    AST_POP_INC: assert property (@(posedge clk) disable iff (!rst_n)
        (op_q == OP_POP) |=> ptr_sp == $past(ptr_sp) + DATA_W'(1)); // R7

endmodule

// File: tb/ptr_data_mem_test.sv
// Scoreboard bench: the driver task models each operation from the
// requirements and queues the expected result; the monitor compares after
// every clock edge.
module ptr_data_mem_test;
    import ptr_mem_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] op = 4'd0;
    logic [7:0] addr = 8'h00, wdata = 8'h00;
    logic [2:0] bit_sel = 3'd0;
    logic       ptr_sel = 1'b0;
    logic [1:0] step = 2'd0;
    logic [7:0] rdata;
    logic       rvalid, bit_out, skip;

    ptr_data_mem uut (
        .clk(clk), .rst_n(rst_n), .op(op), .addr(addr), .wdata(wdata),
        .bit_sel(bit_sel), .ptr_sel(ptr_sel), .step(step),
        .rdata(rdata), .rvalid(rvalid), .bit_out(bit_out), .skip(skip)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        bit         rv;
        logic [7:0] rd;
        bit         tst;
        bit         bt;
        bit         sk;
        string      tag;
    } exp_t;

    exp_t       q[$];
    int         checks = 0, fails = 0;
    logic [7:0] m [256];

    function automatic bit mapped(input logic [7:0] a);
        return (a < 8'h70) || (a >= 8'hF0);
    endfunction

    function automatic logic [7:0] peek(input logic [7:0] a);
        return mapped(a) ? m[a] : 8'h00;
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic issue(input mem_op_e o, input logic [7:0] a, input logic [7:0] d,
                         input logic [2:0] bs, input logic ps, input step_e st,
                         input string tag);
        logic [7:0] eff, cur, nv, pa;
        bit         wr, stp, up;
        exp_t       e;
        eff = a; pa = 8'h00; stp = 0; up = 0;
        case (o)
            OP_IRD, OP_IWR: begin
                pa  = ps ? 8'hFC : 8'hFE;
                eff = m[pa];
                stp = (st == STEP_INC) || (st == STEP_DEC);
                up  = (st == STEP_INC);
            end
            OP_PUSH: begin pa = 8'hFD; eff = m[pa]; stp = 1; up = 0; end
            OP_POP:  begin pa = 8'hFD; eff = m[pa] + 8'h01; stp = 1; up = 1; end
            default: eff = a;
        endcase
        cur = peek(eff);
        case (o)
            OP_BSET:    nv = cur | (8'h01 << bs);
            OP_BCLR:    nv = cur & ~(8'h01 << bs);
            OP_DECSKIP: nv = cur - 8'h01;
            default:    nv = d;
        endcase
        wr = (o == OP_WR) || (o == OP_IWR) || (o == OP_PUSH) || (o == OP_BSET) ||
             (o == OP_BCLR) || ((o == OP_DECSKIP) && eff >= 8'hF0);
        e.rv  = (o == OP_RD) || (o == OP_IRD) || (o == OP_POP) || (o == OP_BTST);
        e.rd  = cur;
        e.tst = (o == OP_BTST);
        e.bt  = cur[bs];
        e.sk  = (o == OP_DECSKIP) && (eff >= 8'hF0) && (nv == 8'h00);
        e.tag = tag;
        if (wr && mapped(eff)) m[eff] = nv;
        if (stp && !(wr && eff == pa)) m[pa] = up ? m[pa] + 8'h01 : m[pa] - 8'h01;
        @(negedge clk);
        op = o; addr = a; wdata = d; bit_sel = bs; ptr_sel = ps; step = st;
        q.push_back(e);
    endtask

    task automatic rd(input logic [7:0] a, input string tag);
        issue(OP_RD, a, 8'h00, 3'd0, 1'b0, STEP_NONE, tag);
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d, input string tag);
        issue(OP_WR, a, d, 3'd0, 1'b0, STEP_NONE, tag);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    // Monitor: compare each queued expectation just after the edge that made it.
    always begin
        exp_t e;
        @(posedge clk);
        #1;
        if (q.size() > 0) begin
            e = q.pop_front();
            check(e.tag, "rvalid", {7'd0, rvalid}, {7'd0, e.rv});
            if (e.rv)  check(e.tag, "rdata", rdata, e.rd);
            if (e.tst) check(e.tag, "bit_out", {7'd0, bit_out}, {7'd0, e.bt});
            check(e.tag, "skip", {7'd0, skip}, {7'd0, e.sk});
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        m[8'hFD] = 8'h6F;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "rvalid after reset", {7'd0, rvalid}, 8'h00);
        check("R1", "skip after reset", {7'd0, skip}, 8'h00);
        rd(8'hFD, "R1 sp reset value");

        // R2: direct access to RAM ends and window bytes
        wr(8'h05, 8'hA5, "R2"); wr(8'h6F, 8'h3C, "R2");
        wr(8'hF0, 8'h11, "R2"); wr(8'hF3, 8'h01, "R2");
        rd(8'h05, "R2 ram low"); rd(8'h6F, "R2 ram top");
        rd(8'hF0, "R2 window"); rd(8'hF3, "R2 window");

        // R3: unmapped hole
        wr(8'h80, 8'h77, "R3");
        rd(8'h80, "R3 unmapped write ignored"); rd(8'h70, "R3 hole low");
        rd(8'hEF, "R3 hole high"); rd(8'h00 + 8'h05, "R3 no alias");

        // R4/R5: pointers at 0xFE and 0xFC
        wr(8'hFE, 8'h05, "R4");
        issue(OP_IRD, 8'h00, 8'h00, 3'd0, 1'b0, STEP_NONE, "R4 primary ptr read");
        wr(8'hFC, 8'h10, "R4");
        issue(OP_IWR, 8'h00, 8'h5A, 3'd0, 1'b1, STEP_INC, "R5 alt ptr write inc");
        rd(8'h10, "R4 indirect write landed"); rd(8'hFC, "R5 alt ptr incremented");
        issue(OP_IRD, 8'h00, 8'h00, 3'd0, 1'b1, STEP_RSV, "R5 step code 3 holds");
        rd(8'hFC, "R5 alt ptr unchanged");
        wr(8'hFF, 8'h9C, "R5"); wr(8'hFE, 8'hFF, "R5");
        issue(OP_IRD, 8'h00, 8'h00, 3'd0, 1'b0, STEP_INC, "R5 read at 0xFF");
        rd(8'hFE, "R5 wrap up to 00");
        wr(8'h00, 8'h42, "R5");
        issue(OP_IRD, 8'h00, 8'h00, 3'd0, 1'b0, STEP_DEC, "R5 read at 0x00");
        rd(8'hFE, "R5 wrap down to FF");

        // R6/R7: stack
        issue(OP_PUSH, 8'h00, 8'hAB, 3'd0, 1'b0, STEP_NONE, "R6");
        issue(OP_PUSH, 8'h00, 8'hCD, 3'd0, 1'b0, STEP_NONE, "R6");
        rd(8'hFD, "R6 sp after two pushes"); rd(8'h6F, "R6 first push slot");
        rd(8'h6E, "R6 second push slot");
        issue(OP_POP, 8'h00, 8'h00, 3'd0, 1'b0, STEP_NONE, "R7 pop last");
        issue(OP_POP, 8'h00, 8'h00, 3'd0, 1'b0, STEP_NONE, "R7 pop first");
        rd(8'hFD, "R7 sp restored");

        // R8/R9: bit operations
        issue(OP_BSET, 8'h05, 8'h00, 3'd1, 1'b0, STEP_NONE, "R8");
        issue(OP_BCLR, 8'h05, 8'h00, 3'd0, 1'b0, STEP_NONE, "R8");
        rd(8'h05, "R8 ram byte bits");
        issue(OP_BSET, 8'hFD, 8'h00, 3'd4, 1'b0, STEP_NONE, "R8");
        rd(8'hFD, "R8 pointer byte bit");
        issue(OP_BSET, 8'h90, 8'h00, 3'd3, 1'b0, STEP_NONE, "R3");
        rd(8'h90, "R3 unmapped bit set ignored");
        issue(OP_BTST, 8'h05, 8'h00, 3'd2, 1'b0, STEP_NONE, "R9 bit set");
        issue(OP_BTST, 8'h05, 8'h00, 3'd0, 1'b0, STEP_NONE, "R9 bit clear");
        rd(8'h05, "R9 byte unchanged");

        // R10: decrement and test
        issue(OP_DECSKIP, 8'hF3, 8'h00, 3'd0, 1'b0, STEP_NONE, "R10 reach zero");
        issue(OP_DECSKIP, 8'hF3, 8'h00, 3'd0, 1'b0, STEP_NONE, "R10 wrap to FF");
        rd(8'hF3, "R10 window value");
        issue(OP_DECSKIP, 8'h05, 8'h00, 3'd0, 1'b0, STEP_NONE, "R10 non-window");
        rd(8'h05, "R10 non-window unchanged");

        // R11: write to the pointer being stepped wins
        wr(8'hFE, 8'hFE, "R11");
        issue(OP_IWR, 8'h00, 8'h33, 3'd0, 1'b0, STEP_INC, "R11");
        rd(8'hFE, "R11 primary keeps written value");
        wr(8'hFD, 8'hFD, "R11");
        issue(OP_PUSH, 8'h00, 8'h44, 3'd0, 1'b0, STEP_NONE, "R11");
        rd(8'hFD, "R11 sp keeps pushed value");

        repeat (3) issue(OP_NOP, 8'h00, 8'h00, 3'd0, 1'b0, STEP_NONE, "R2 idle");
        repeat (3) @(posedge clk);
        #2;
        finish_run();
    end

endmodule